// File: doc/BRIEF.md
# Modem Status and Control Unit

This unit sits beside a UART's data path and looks after its modem handshake lines. Four asynchronous modem-status inputs (ring indicator, clear-to-send, carrier detect, data-set-ready) are brought into the clock domain through a synchronizer chain. Their current levels can be read from a line register. Clear-to-send and carrier detect are also watched for transitions. Each of these two lines has a pending-event flag, which is held by a small two-state machine, an interrupt enable and an any-edge select. The enabled pending flags are ORed into a single interrupt bit. The main interrupt logic of the UART masks and reports that bit.

Software acknowledges events by reading the line register, and a read with no other purpose does the job. Any edge that arrives in the same cycle as the acknowledging read is kept. A separate control register holds the data-terminal-ready and request-to-send requests. The two pins drive the inverse of the stored bits, so writing 1 asserts an active-low line.

Each edge channel runs the state machine `evt_state_t` with two states. `EVT_IDLE` means nothing is pending and `EVT_PEND` means an event waits to be acknowledged. There are three transitions. *capture* moves `EVT_IDLE` to `EVT_PEND` on a detected edge. *acknowledge* moves `EVT_PEND` to `EVT_IDLE` on a line-register read in a cycle with no edge. *hold* keeps `EVT_PEND` when an edge and a read coincide, and also keeps it in any cycle without a read.

Top module: `modem_ctl_unit`

## Requirements
- R1: Reading address 0 (line register) returns the synchronized levels of ring (bit 0), clear-to-send (bit 1), carrier detect (bit 2) and data-set-ready (bit 3). A change on a pin reaches these bits two clock edges later, and is not yet visible after one edge.
- R2: With its any-edge select clear, a rising edge on clear-to-send sets bit 4 and a rising edge on carrier detect sets bit 5. A falling edge sets neither bit. An edge on a pin shows in the status bit three clock edges after the pin changes.
- R3: With the any-edge select set (bit 8 for clear-to-send, bit 9 for carrier detect), both rising and falling edges set the channel's status bit.
- R4: A line-register read returns the status bits as they were before the read, then clears them at the clock edge that ends the read.
- R5: An edge detected in the same cycle as a clearing read leaves the status bit set.
- R6: `ext_irq` is the OR of bit 4 ANDed with enable bit 6 and bit 5 ANDed with enable bit 7. Status bits are set whether or not their enable is set.
- R7: Address 1 holds the data-terminal-ready request (bit 0) and the request-to-send request (bit 1). `dtr_pin` and `rts_pin` drive the inverse of these bits from the clock edge that ends the write.
- R8: A write to address 0 changes only the enables and any-edge selects (bits 9:6). Status and level bits ignore written data. A read of address 1 leaves status bits untouched, and strobes without `bus_sel` have no effect.
- R9: After reset, all configuration bits, control bits and status bits are 0, both pins are high and `ext_irq` is low.
- R10: Edges on ring and data-set-ready never set any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | Register address: 0 line register, 1 control register |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 10 | Read data, combinational from address |
| ring_in | input | 1 | Ring indicator input, asynchronous |
| cts_in | input | 1 | Clear-to-send input, asynchronous |
| dcd_in | input | 1 | Carrier detect input, asynchronous |
| dsr_in | input | 1 | Data-set-ready input, asynchronous |
| dtr_pin | output | 1 | Data-terminal-ready pin, inverse of control bit 0 |
| rts_pin | output | 1 | Request-to-send pin, inverse of control bit 1 |
| ext_irq | output | 1 | Combined enabled edge-event interrupt |

## Verification
Several properties are checked on every cycle:
- an acknowledging read clears a flag unless an edge coincides with it, and a coinciding edge keeps the flag set;
- a flag only rises after a detected edge;
- a falling level never raises a flag while its any-edge select is clear;
- `ext_irq` never rises without an enabled pending flag;
- each control write reaches the pins inverted in the next cycle.

Other behaviours can only be shown by the bench's scenarios. These are the exact two-edge and three-edge latencies from a pin to the readable bits, the pre-clear value returned by the read itself, the register layout and readback, and the way ring and data-set-ready stay out of the status bits.

// File: rtl/mctl_pkg.sv
package mctl_pkg;

    // Register data width and address codes
    localparam int REG_W     = 10;
    localparam bit ADDR_LINE = 1'b0;
    localparam bit ADDR_CTRL = 1'b1;

    // Synchronized input vector order (also line register bits 3:0)
    localparam int NUM_LINES = 4;
    localparam int LINE_RING = 0;
    localparam int LINE_CTS  = 1;
    localparam int LINE_DCD  = 2;
    localparam int LINE_DSR  = 3;

    // Edge channels: 0 = clear-to-send, 1 = carrier detect
    localparam int NUM_EVT   = 2;

    // Line register field bases
    localparam int EVT_LSB   = 4;
    localparam int EN_LSB    = 6;
    localparam int ANY_LSB   = 8;

    // Control register bits
    localparam int CTL_DTR   = 0;
    localparam int CTL_RTS   = 1;
    localparam int CTL_W     = 2;

    typedef enum logic {
        EVT_IDLE = 1'b0,
        EVT_PEND = 1'b1
    } evt_state_t;

endpackage

// File: rtl/mctl_sync.sv
module mctl_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mctl_edge_chan.sv
module mctl_edge_chan
    import mctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic any_edge,
    input  logic ack,
    output logic pend,
    output logic hit,
    output logic prev_lvl
);

    evt_state_t state_q, state_d;

    // Previous synchronized sample
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= lvl;
    end

    // Edge qualification: any change, or rising only
    assign hit = any_edge ? (lvl ^ prev_lvl) : (lvl & ~prev_lvl);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EVT_IDLE;
        else        state_q <= state_d;
    end

    // Next state: capture, acknowledge, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EVT_IDLE: begin
                if (hit) state_d = EVT_PEND;
            end
            EVT_PEND: begin
                if (ack && !hit) state_d = EVT_IDLE;
            end
            default: state_d = EVT_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        pend = (state_q == EVT_PEND);
    end

endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
    import mctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             ring_in,
    input  logic             cts_in,
    input  logic             dcd_in,
    input  logic             dsr_in,
    output logic             dtr_pin,
    output logic             rts_pin,
    output logic             ext_irq
);

    logic [NUM_LINES-1:0] raw_lvl;
    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_EVT-1:0]   evt_lvl;
    logic [NUM_EVT-1:0]   evt_pend;
    logic [NUM_EVT-1:0]   evt_hit;
    logic [NUM_EVT-1:0]   evt_prev;
    logic [NUM_EVT-1:0]   en_q;
    logic [NUM_EVT-1:0]   any_q;
    logic [CTL_W-1:0]     ctl_q;
    logic                 wr_line, wr_ctrl, rd_line;
    logic                 unused_wbits;

    assign raw_lvl = {dsr_in, dcd_in, cts_in, ring_in};

    mctl_sync #(
        .W      (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lvl),
        .q     (sync_lvl)
    );

    // Access decode
    assign wr_line = bus_sel & bus_wr & (bus_addr == ADDR_LINE);
    assign wr_ctrl = bus_sel & bus_wr & (bus_addr == ADDR_CTRL);
    assign rd_line = bus_sel & bus_rd & (bus_addr == ADDR_LINE);

    // Configuration and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            any_q <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_line) begin
                en_q  <= bus_wdata[EN_LSB  +: NUM_EVT];
                any_q <= bus_wdata[ANY_LSB +: NUM_EVT];
            end
            if (wr_ctrl) begin
                ctl_q <= bus_wdata[CTL_W-1:0];
            end
        end
    end

    assign unused_wbits = ^bus_wdata[EN_LSB-1:CTL_W];

    // Edge channels for clear-to-send and carrier detect
    generate
        for (genvar g = 0; g < NUM_EVT; g++) begin : g_chan
            localparam int SRC = LINE_CTS + g;
            assign evt_lvl[g] = sync_lvl[SRC];
            mctl_edge_chan u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .lvl      (evt_lvl[g]),
                .any_edge (any_q[g]),
                .ack      (rd_line),
                .pend     (evt_pend[g]),
                .hit      (evt_hit[g]),
                .prev_lvl (evt_prev[g])
            );
        end
    endgenerate

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_LINE) begin
            bus_rdata[NUM_LINES-1:0]        = sync_lvl;
            bus_rdata[EVT_LSB +: NUM_EVT]   = evt_pend;
            bus_rdata[EN_LSB  +: NUM_EVT]   = en_q;
            bus_rdata[ANY_LSB +: NUM_EVT]   = any_q;
        end else begin
            bus_rdata[CTL_W-1:0]            = ctl_q;
        end
    end

    assign ext_irq = |(evt_pend & en_q);
    assign dtr_pin = ~ctl_q[CTL_DTR];
    assign rts_pin = ~ctl_q[CTL_RTS];

endmodule

// File: rtl/mctl_checker.sv
module mctl_checker
    import mctl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_ctrl,
    input logic               rd_line,
    input logic [REG_W-1:0]   bus_wdata,
    input logic [NUM_EVT-1:0] evt_lvl,
    input logic [NUM_EVT-1:0] evt_prev,
    input logic [NUM_EVT-1:0] evt_hit,
    input logic [NUM_EVT-1:0] evt_pend,
    input logic [NUM_EVT-1:0] en_q,
    input logic [NUM_EVT-1:0] any_q,
    input logic               ext_irq,
    input logic               dtr_pin,
    input logic               rts_pin
);

    generate
        for (genvar g = 0; g < NUM_EVT; g++) begin : g_chk
            // R4
            ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_line && !evt_hit[g]) |=> !evt_pend[g]);
            // R5
            edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_line && evt_hit[g]) |=> evt_pend[g]);
            // R2
            rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(evt_pend[g]) |-> $past(evt_hit[g]));
            // R2
            fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!any_q[g] && !evt_pend[g] && evt_prev[g] && !evt_lvl[g]) |=> !evt_pend[g]);
        end
    endgenerate

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> |(evt_pend & en_q));

    // R7
    pin_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ((dtr_pin == !$past(bus_wdata[CTL_DTR])) &&
                     (rts_pin == !$past(bus_wdata[CTL_RTS]))));

endmodule

bind modem_ctl_unit mctl_checker u_mctl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .rd_line   (rd_line),
    .bus_wdata (bus_wdata),
    .evt_lvl   (evt_lvl),
    .evt_prev  (evt_prev),
    .evt_hit   (evt_hit),
    .evt_pend  (evt_pend),
    .en_q      (en_q),
    .any_q     (any_q),
    .ext_irq   (ext_irq),
    .dtr_pin   (dtr_pin),
    .rts_pin   (rts_pin)
);

// File: tb/tb_modem_ctl_unit.sv
`timescale 1ns/1ps
module tb_modem_ctl_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [9:0] bus_wdata = '0;
    logic [9:0] bus_rdata;
    logic       ring_in = 1'b0, cts_in = 1'b0, dcd_in = 1'b0, dsr_in = 1'b0;
    logic       dtr_pin, rts_pin, ext_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    modem_ctl_unit dut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ring_in(ring_in), .cts_in(cts_in), .dcd_in(dcd_in), .dsr_in(dsr_in),
        .dtr_pin(dtr_pin), .rts_pin(rts_pin), .ext_irq(ext_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Starts at a negedge, samples data, ends at the next negedge
    task automatic bus_read(input logic a, output logic [9:0] d);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic a, input logic [9:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic t_reset;
        logic [9:0] d;
        check("R9 dtr_pin", dtr_pin, 1'b1);
        check("R9 rts_pin", rts_pin, 1'b1);
        check("R9 ext_irq", ext_irq, 1'b0);
        bus_read(1'b0, d); check("R9 line reg", d, 10'h000);
        bus_read(1'b1, d); check("R9 ctrl reg", d, 10'h000);
    endtask

    task automatic t_levels;
        logic [9:0] d;
        ring_in = 1'b1; dsr_in = 1'b1;
        wait_cycles(1);
        bus_read(1'b0, d); check("R1 one edge old", d, 10'h000);
        bus_read(1'b0, d); check("R1 two edges new", d, 10'h009);
        wait_cycles(3);
        bus_read(1'b0, d); check("R10 ring/dsr no status", d, 10'h009);
        ring_in = 1'b0; dsr_in = 1'b0;
        wait_cycles(4);
        bus_read(1'b0, d); check("R10 ring/dsr fall", d, 10'h000);
    endtask

    task automatic t_rise;
        logic [9:0] d;
        cts_in = 1'b1; wait_cycles(4);
        bus_read(1'b0, d); check("R2 cts rise", d, 10'h012);
        bus_read(1'b0, d); check("R4 cleared", d, 10'h002);
        cts_in = 1'b0; wait_cycles(4);
        bus_read(1'b0, d); check("R2 cts fall ignored", d, 10'h000);
        dcd_in = 1'b1; wait_cycles(4);
        bus_read(1'b0, d); check("R2 dcd rise", d, 10'h024);
        bus_read(1'b0, d); check("R4 dcd cleared", d, 10'h004);
        dcd_in = 1'b0; wait_cycles(4);
        bus_read(1'b0, d); check("R2 dcd fall ignored", d, 10'h000);
    endtask

    task automatic t_anyedge;
        logic [9:0] d;
        bus_write(1'b0, 10'h300);
        bus_read(1'b0, d); check("R3 config readback", d, 10'h300);
        cts_in = 1'b1; wait_cycles(4);
        bus_read(1'b0, d); check("R3 cts rise", d, 10'h312);
        cts_in = 1'b0; wait_cycles(4);
        bus_read(1'b0, d); check("R3 cts fall", d, 10'h310);
        dcd_in = 1'b1; wait_cycles(4);
        bus_read(1'b0, d);
        dcd_in = 1'b0; wait_cycles(4);
        bus_read(1'b0, d); check("R3 dcd fall", d, 10'h320);
        bus_read(1'b0, d); check("R4 any cleared", d, 10'h300);
        bus_write(1'b0, 10'h000);
    endtask

    task automatic t_irq;
        logic [9:0] d;
        bus_write(1'b0, 10'h040);
        dcd_in = 1'b1; wait_cycles(4);
        check("R6 disabled dcd no irq", ext_irq, 1'b0);
        cts_in = 1'b1; wait_cycles(4);
        check("R6 enabled cts irq", ext_irq, 1'b1);
        bus_read(1'b0, d); check("R6 status regardless of enable", d, 10'h076);
        check("R6 irq drops after ack", ext_irq, 1'b0);
        cts_in = 1'b0; dcd_in = 1'b0; wait_cycles(4);
        bus_write(1'b0, 10'h000);
    endtask

    task automatic t_collision;
        logic [9:0] d;
        cts_in = 1'b1; wait_cycles(2);
        bus_read(1'b0, d); check("R4 pre-clear value", d, 10'h002);
        bus_read(1'b0, d); check("R5 coinciding edge kept", d, 10'h012);
        bus_read(1'b0, d); check("R4 clear after", d, 10'h002);
        cts_in = 1'b0; wait_cycles(4);
        bus_read(1'b0, d);
    endtask

    task automatic t_ctrl;
        logic [9:0] d;
        bus_write(1'b1, 10'h001);
        check("R7 dtr low", dtr_pin, 1'b0); check("R7 rts high", rts_pin, 1'b1);
        bus_read(1'b1, d); check("R7 ctrl readback", d, 10'h001);
        bus_write(1'b1, 10'h002);
        check("R7 dtr high", dtr_pin, 1'b1); check("R7 rts low", rts_pin, 1'b0);
        bus_write(1'b1, 10'h003);
        check("R7 both low", {dtr_pin, rts_pin}, 2'b00);
        bus_write(1'b1, 10'h000);
        check("R7 both high", {dtr_pin, rts_pin}, 2'b11);
    endtask

    task automatic t_ignore;
        logic [9:0] d;
        cts_in = 1'b1; wait_cycles(4);
        bus_write(1'b0, 10'h03F);
        bus_read(1'b1, d); check("R8 ctrl read", d, 10'h000);
        bus_read(1'b0, d); check("R8 status survives write", d, 10'h012);
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 10'h003;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        check("R8 unselected write ignored", {dtr_pin, rts_pin}, 2'b11);
        cts_in = 1'b0; wait_cycles(4);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_levels();
        t_rise();
        t_anyedge();
        t_irq();
        t_collision();
        t_ctrl();
        t_ignore();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule